// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

The block takes stereo PCM sample pairs from a converter datapath and sends them one bit at a time on a serial data line. The bits are aligned to a bit clock and a frame clock. Four framing conventions can be selected: left-aligned, right-aligned, the two-channel inter-IC sound convention, and a pulse-synchronised DSP framing that sends both channels back to back after a one-slot sync pulse. Word length is selectable among 16, 18, 20 and 24 bits.

The block runs on one fast system clock. In master mode it builds the bit clock and the frame clock itself and drives them out. In slave mode it follows bit and frame clocks that arrive on input pins. In both modes the outgoing data changes only after falling bit-clock edges. A producer hands over left/right pairs through a ready/valid handshake. The block holds one pair in waiting and takes it into use at the start of each frame. If no pair is waiting, the previous pair is sent again and an underrun flag is raised for that frame.

Top module: `pcm_serial_tx`

## Requirements
- R1: `wlen_sel` picks the word length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Samples arrive MSB-aligned in 24-bit fields, and only the upper word-length bits are ever sent.
- R2: With `fmt`=1 (left-aligned), the frame clock is high for the left half-frame and low for the right. Each word's MSB occupies the first bit slot of its half.
- R3: With `fmt`=2 (inter-IC sound), the frame clock is low for the left half-frame and high for the right. Each word's MSB occupies the second bit slot of its half.
- R4: With `fmt`=0 (right-aligned), the frame clock is high for the left half-frame and low for the right. Each word's LSB occupies the last bit slot of its half.
- R5: With `fmt`=3 (DSP), the frame clock is high for only slot 0 of the frame. The left word starts in slot 1 and the right word follows it with no gap.
- R6: `sdo` changes only after a falling bit-clock edge, so it holds steady while the bit clock is high.
- R7: Every bit slot not occupied by a word is driven low.
- R8: With `master_en`=1, `bus_drive` is high and the bit clock toggles every `BCLK_HALF` system clocks. The frame clock changes only together with a falling bit-clock edge, and a frame lasts 2*`SLOT_W` bit periods. With `master_en`=0, the block times itself from `bclk_in`/`fclk_in`.
- R9: `in_ready` is high exactly when no pair is waiting. A pair is taken when `in_valid` and `in_ready` are both high, and it is sent in the next frame that starts. Pairs are sent in the order they were taken.
- R10: If a frame starts with no pair waiting, that frame repeats the previous pair and `underrun` is high for the frame. `underrun` drops again at the first frame start that finds a pair waiting.
- R11: Under reset, `sdo`, `underrun`, `bclk_out` and `fclk_out` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1: generate bit/frame clocks, 0: follow input clocks |
| fmt | input | 2 | Framing: 0 right-aligned, 1 left-aligned, 2 inter-IC sound, 3 DSP |
| wlen_sel | input | 2 | Word length code (16/18/20/24) |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | No pair waiting; an offered pair is taken |
| in_left | input | 24 | Left sample, MSB-aligned |
| in_right | input | 24 | Right sample, MSB-aligned |
| bclk_in | input | 1 | External bit clock (slave) |
| fclk_in | input | 1 | External frame clock (slave) |
| bclk_out | output | 1 | Generated bit clock (master) |
| fclk_out | output | 1 | Generated frame clock (master) |
| bus_drive | output | 1 | Enable for the clock pin drivers (master) |
| sdo | output | 1 | Serial data |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
The assertions take for granted that configuration inputs (`fmt`, `wlen_sel`, `master_en`) change only while reset is held. In slave mode they also assume that external clocks are synchronous to `clk`, have half periods of at least two system clocks, move the frame clock only together with a falling bit clock, and give frames of exactly 2*`SLOT_W` bits. The bench changes configuration only under reset. It generates slave clocks on falling system-clock edges, using four-cycle half periods and the frame-clock rule of the selected format, so every slave run stays inside those assumptions.

// File: rtl/pcm_tx_pkg.sv
// Shared types and helper functions for the serial audio transmitter.
// Assumes sample words are carried MSB-aligned in SAMPLE_W-bit fields.
package pcm_tx_pkg;

    localparam int SAMPLE_W = 24;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_I2S = 2'd2,
        FMT_DSP = 2'd3
    } frame_fmt_e;

    // Word length in bits for a two-bit length code.
    function automatic int word_len(input logic [1:0] code);
        return (code == 2'd3) ? 24 : 16 + 2 * int'(code);
    endfunction

    // Frame clock level that a master drives during slot idx of a frame.
    function automatic logic fclk_level(input frame_fmt_e f, input int idx, input int slot_w);
        case (f)
            FMT_I2S: return idx >= slot_w;
            FMT_DSP: return idx == 0;
            default: return idx < slot_w;
        endcase
    endfunction

endpackage

// File: rtl/ptx_clkgen.sv
// Bit/frame clock source and falling-edge detector.
// In master mode it divides clk to form the bit clock and derives the
// frame clock from a slot counter. In slave mode it registers the external
// clocks once. It assumes that external clocks are synchronous to clk and
// that their half periods last at least two clk cycles.
module ptx_clkgen
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W    = 32,
    parameter int BCLK_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  frame_fmt_e fmt,
    input  logic       bclk_in,
    input  logic       fclk_in,
    output logic       bclk_out,
    output logic       fclk_out,
    output logic       fall_stb,
    output logic       fclk_now
);
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int DIV_W      = $clog2(BCLK_HALF);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(FRAME_BITS - 1);
    localparam logic [DIV_W-1:0] DIV_END   = DIV_W'(BCLK_HALF - 1);

    logic [DIV_W-1:0] div_q;
    logic [IDX_W-1:0] mslot_q;
    logic [IDX_W-1:0] mslot_nxt;
    logic             bclk_q;
    logic             fclk_q;
    logic             bclk_in_q;
    logic             fclk_in_q;
    logic             bclk_prev_q;
    logic             bclk_sel;

    // Next master slot number, wrapping at the end of the frame.
    always_comb begin
        mslot_nxt = (mslot_q == LAST_SLOT) ? '0 : mslot_q + 1'b1;
    end

    // Master divider: toggle the bit clock and step the frame on each fall.
    always_ff @(posedge clk) begin
        if (!rst_n || !master_en) begin
            div_q   <= '0;
            bclk_q  <= 1'b0;
            fclk_q  <= 1'b0;
            mslot_q <= LAST_SLOT;
        end else if (div_q == DIV_END) begin
            div_q  <= '0;
            bclk_q <= ~bclk_q;
            if (bclk_q) begin
                mslot_q <= mslot_nxt;
                fclk_q  <= fclk_level(fmt, int'(mslot_nxt), SLOT_W);
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Slave capture of the external clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_in_q <= 1'b0;
            fclk_in_q <= 1'b0;
        end else begin
            bclk_in_q <= bclk_in;
            fclk_in_q <= fclk_in;
        end
    end

    // Source selection for the timing path.
    always_comb begin
        bclk_sel = master_en ? bclk_q : bclk_in_q;
        fclk_now = master_en ? fclk_q : fclk_in_q;
    end

    // Delay line for falling-edge detection of the selected bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_prev_q <= 1'b0;
        end else begin
            bclk_prev_q <= bclk_sel;
        end
    end

    assign fall_stb = bclk_prev_q & ~bclk_sel;
    assign bclk_out = bclk_q;
    assign fclk_out = fclk_q;

endmodule

// File: rtl/ptx_framer.sv
// Frame position tracker. On each falling bit-clock strobe it checks the
// frame clock for the start edge of the selected format (a fall for the
// inter-IC sound convention, a rise otherwise) and numbers the slots. It
// assumes that the frame clock only moves at a falling bit clock.
module ptx_framer
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  frame_fmt_e                        fmt,
    input  logic                              fall_stb,
    input  logic                              fclk_now,
    output logic                              frame_start,
    output logic                              in_frame,
    output logic [$clog2(2*SLOT_W)-1:0]       slot_now
);
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(FRAME_BITS - 1);

    logic             fclk_last_q;
    logic             synced_q;
    logic [IDX_W-1:0] slot_q;
    logic             start_edge;

    // Start-edge decode and slot numbering for the current strobe.
    always_comb begin
        if (fmt == FMT_I2S) begin
            start_edge = fclk_last_q & ~fclk_now;
        end else begin
            start_edge = ~fclk_last_q & fclk_now;
        end
        frame_start = fall_stb & start_edge;
        if (frame_start) begin
            slot_now = '0;
        end else if (slot_q == LAST_SLOT) begin
            slot_now = LAST_SLOT;
        end else begin
            slot_now = slot_q + 1'b1;
        end
        in_frame = frame_start | synced_q;
    end

    // Position state, advanced once per bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fclk_last_q <= 1'b0;
            synced_q    <= 1'b0;
            slot_q      <= LAST_SLOT;
        end else if (fall_stb) begin
            fclk_last_q <= fclk_now;
            slot_q      <= slot_now;
            if (frame_start) begin
                synced_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ptx_serializer.sv
// Sample holding and bit selection. It keeps one waiting pair behind a
// ready/valid handshake, takes it into use at frame start (or repeats the
// old pair and flags underrun), and drives the bit for each slot.
// It assumes that slot_now is valid whenever fall_stb is high.
module ptx_serializer
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  frame_fmt_e                    fmt,
    input  logic [1:0]                    wlen_sel,
    input  logic                          fall_stb,
    input  logic                          frame_start,
    input  logic                          in_frame,
    input  logic [$clog2(2*SLOT_W)-1:0]   slot_now,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [SAMPLE_W-1:0]           in_left,
    input  logic [SAMPLE_W-1:0]           in_right,
    output logic                          sdo,
    output logic                          underrun
);
    logic [SAMPLE_W-1:0] pend_l_q, pend_r_q;
    logic [SAMPLE_W-1:0] act_l_q, act_r_q;
    logic [SAMPLE_W-1:0] cur_l, cur_r;
    logic                pend_vld_q;
    logic                load;
    logic                bit_sel;

    assign in_ready = ~pend_vld_q;
    assign load     = frame_start & pend_vld_q;

    // Waiting pair register behind the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld_q <= 1'b0;
            pend_l_q   <= '0;
            pend_r_q   <= '0;
        end else if (load) begin
            pend_vld_q <= 1'b0;
        end else if (in_valid && !pend_vld_q) begin
            pend_vld_q <= 1'b1;
            pend_l_q   <= in_left;
            pend_r_q   <= in_right;
        end
    end

    // Pair being sent, and the underrun flag, both updated at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_l_q  <= '0;
            act_r_q  <= '0;
            underrun <= 1'b0;
        end else if (frame_start) begin
            underrun <= ~pend_vld_q;
            if (pend_vld_q) begin
                act_l_q <= pend_l_q;
                act_r_q <= pend_r_q;
            end
        end
    end

    // Words visible to slot 0 of a new frame include a pair being loaded.
    always_comb begin
        cur_l = load ? pend_l_q : act_l_q;
        cur_r = load ? pend_r_q : act_r_q;
    end

    // Map the slot number to a word bit for the selected framing.
    always_comb begin
        int idx, pos, k, wl;
        logic use_r, inw;
        logic [SAMPLE_W-1:0] w_sh;
        wl    = word_len(wlen_sel);
        idx   = int'(slot_now);
        use_r = idx >= SLOT_W;
        pos   = use_r ? idx - SLOT_W : idx;
        k     = 0;
        inw   = 1'b0;
        case (fmt)
            FMT_LJ: begin
                k   = pos;
                inw = pos < wl;
            end
            FMT_I2S: begin
                k   = pos - 1;
                inw = (pos >= 1) && (pos <= wl);
            end
            FMT_RJ: begin
                k   = pos - (SLOT_W - wl);
                inw = k >= 0;
            end
            default: begin
                if (idx >= 1 && idx <= wl) begin
                    use_r = 1'b0;
                    k     = idx - 1;
                    inw   = 1'b1;
                end else if (idx > wl && idx <= 2 * wl) begin
                    use_r = 1'b1;
                    k     = idx - 1 - wl;
                    inw   = 1'b1;
                end else begin
                    use_r = 1'b0;
                end
            end
        endcase
        if (!inw) begin
            k = 0;
        end
        w_sh    = (use_r ? cur_r : cur_l) << k;
        bit_sel = inw & w_sh[SAMPLE_W-1];
    end

    // Output bit register, updated only on a falling bit-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b0;
        end else if (fall_stb) begin
            sdo <= in_frame & bit_sel;
        end
    end

endmodule

// File: rtl/pcm_serial_tx.sv
// Top level of the multi-format audio serial transmitter. It joins the
// clock source, the frame tracker and the serializer. It assumes that the
// configuration inputs are changed only while reset is held.
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W    = 32,
    parameter int BCLK_HALF = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_en,
    input  logic [1:0]          fmt,
    input  logic [1:0]          wlen_sel,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                bclk_in,
    input  logic                fclk_in,
    output logic                bclk_out,
    output logic                fclk_out,
    output logic                bus_drive,
    output logic                sdo,
    output logic                underrun
);
    localparam int IDX_W = $clog2(2 * SLOT_W);

    frame_fmt_e       fmt_e;
    logic             fall_stb;
    logic             fclk_now;
    logic             frame_start;
    logic             in_frame;
    logic [IDX_W-1:0] slot_now;

    assign fmt_e     = frame_fmt_e'(fmt);
    assign bus_drive = master_en;

    ptx_clkgen #(.SLOT_W(SLOT_W), .BCLK_HALF(BCLK_HALF)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .master_en(master_en),
        .fmt      (fmt_e),
        .bclk_in  (bclk_in),
        .fclk_in  (fclk_in),
        .bclk_out (bclk_out),
        .fclk_out (fclk_out),
        .fall_stb (fall_stb),
        .fclk_now (fclk_now)
    );

    ptx_framer #(.SLOT_W(SLOT_W)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt_e),
        .fall_stb   (fall_stb),
        .fclk_now   (fclk_now),
        .frame_start(frame_start),
        .in_frame   (in_frame),
        .slot_now   (slot_now)
    );

    ptx_serializer #(.SLOT_W(SLOT_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt_e),
        .wlen_sel   (wlen_sel),
        .fall_stb   (fall_stb),
        .frame_start(frame_start),
        .in_frame   (in_frame),
        .slot_now   (slot_now),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_left    (in_left),
        .in_right   (in_right),
        .sdo        (sdo),
        .underrun   (underrun)
    );

endmodule

// File: rtl/pcm_serial_tx_chk.sv
// Protocol checker for pcm_serial_tx, attached with bind. It assumes that
// configuration inputs are stable outside reset.
module pcm_serial_tx_chk #(
    parameter int BCLK_HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic master_en,
    input logic in_valid,
    input logic in_ready,
    input logic bclk_out,
    input logic fclk_out,
    input logic sdo,
    input logic underrun,
    input logic fall_stb,
    input logic frame_start
);
    logic        bclk_seen_q;
    logic [15:0] held_q;
    logic        bclk_tog;

    assign bclk_tog = bclk_out != bclk_seen_q;

    // Count how many cycles the generated bit clock has held its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_seen_q <= 1'b0;
            held_q      <= 16'd0;
        end else begin
            bclk_seen_q <= bclk_out;
            if (bclk_tog) begin
                held_q <= 16'd1;
            end else if (held_q != 16'hFFFF) begin
                held_q <= held_q + 16'd1;
            end
        end
    end

    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) (sdo != $past(sdo)) |-> $past(fall_stb)); // R6
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready); // R9
    AST_UNDERRUN_AT_START: assert property (@(posedge clk) disable iff (!rst_n) (underrun != $past(underrun)) |-> $past(frame_start)); // R10
    AST_FCLK_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n) (master_en && (fclk_out != $past(fclk_out))) |-> ($past(bclk_out) && !bclk_out)); // R8
    AST_BCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) (master_en && bclk_tog) |-> (held_q == 16'(BCLK_HALF))); // R8

endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.BCLK_HALF(BCLK_HALF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_en  (master_en),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .bclk_out   (bclk_out),
    .fclk_out   (fclk_out),
    .sdo        (sdo),
    .underrun   (underrun),
    .fall_stb   (fall_stb),
    .frame_start(frame_start)
);

// File: tb/tb_pcm_serial_tx.sv
// Scoreboard bench: the driver queues each accepted pair, and the monitor
// decodes frames from the pins and compares them with the queue.
module tb_pcm_serial_tx;

    localparam int SLOT_W = 32;
    localparam int HALF   = 4;
    localparam int FB     = 2 * SLOT_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b1;
    logic [1:0]  fmt = 2'd1;
    logic [1:0]  wlen_sel = 2'd3;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        bclk_in = 1'b0;
    logic        fclk_in = 1'b0;
    logic        bclk_out, fclk_out, bus_drive, sdo, underrun;

    always #5 clk = ~clk;

    pcm_serial_tx #(.SLOT_W(SLOT_W), .BCLK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .fmt(fmt),
        .wlen_sel(wlen_sel), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .bclk_in(bclk_in),
        .fclk_in(fclk_in), .bclk_out(bclk_out), .fclk_out(fclk_out),
        .bus_drive(bus_drive), .sdo(sdo), .underrun(underrun)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [47:0] expq[$];
    logic [47:0] last_exp;
    bit          mon_en = 1'b0;
    bit          sgen_en = 1'b0;
    bit          rx_on;
    int          rx_idx;
    logic        prev_fc;
    logic [FB-1:0] rxd, rxf;
    logic        rise_sdo;
    int          r6_bad;
    int          under_frames;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Word length from the R1 code table.
    function automatic int wl_of(input logic [1:0] c);
        case (c)
            2'd0: return 16;
            2'd1: return 18;
            2'd2: return 20;
            default: return 24;
        endcase
    endfunction

    // Frame clock level per slot (R2, R3, R4, R5).
    function automatic logic fc_rule(input logic [1:0] f, input int s);
        if (f == 2'd2) return s >= SLOT_W;
        if (f == 2'd3) return s == 0;
        return s < SLOT_W;
    endfunction

    function automatic string req_of(input logic [1:0] f);
        case (f)
            2'd0: return "R4";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R5";
        endcase
    endfunction

    // Expected slot contents of one frame; unused slots stay low (R7).
    function automatic logic [FB-1:0] exp_frame(input logic [1:0] f, input int w,
                                                 input logic [23:0] l, input logic [23:0] r);
        logic [FB-1:0] v;
        v = '0;
        for (int j = 0; j < w; j++) begin
            case (f)
                2'd1: begin v[j] = l[23-j]; v[SLOT_W+j] = r[23-j]; end
                2'd2: begin v[1+j] = l[23-j]; v[SLOT_W+1+j] = r[23-j]; end
                2'd0: begin v[SLOT_W-w+j] = l[23-j]; v[FB-w+j] = r[23-j]; end
                default: begin v[1+j] = l[23-j]; v[1+w+j] = r[23-j]; end
            endcase
        end
        return v;
    endfunction

    function automatic logic [FB-1:0] exp_fclk(input logic [1:0] f);
        logic [FB-1:0] v;
        for (int s = 0; s < FB; s++) v[s] = fc_rule(f, s);
        return v;
    endfunction

    wire bclk_mon = master_en ? bclk_out : bclk_in;
    wire fclk_mon = master_en ? fclk_out : fclk_in;

    // Monitor: receive a bit on each rising bit clock, compare each full frame.
    initial begin
        forever begin
            @(posedge bclk_mon);
            #1;
            if (mon_en) begin
                logic fc, st;
                logic [47:0] e;
                fc = fclk_mon;
                st = (fmt == 2'd2) ? (prev_fc && !fc) : (!prev_fc && fc);
                prev_fc = fc;
                if (st) begin
                    if (rx_on && master_en)
                        check(rx_idx == FB - 1, "R8", "frame length", 64'(rx_idx + 1), 64'(FB));
                    rx_on = 1'b1;
                    rx_idx = 0;
                end else if (rx_on && rx_idx < FB) begin
                    rx_idx++;
                end
                rise_sdo = sdo;
                if (rx_on && rx_idx < FB) begin
                    rxd[rx_idx] = sdo;
                    rxf[rx_idx] = fc;
                end
                if (rx_on && rx_idx == FB - 1) begin
                    if (underrun) begin
                        under_frames++;
                        e = last_exp;
                    end else if (expq.size() > 0) begin
                        e = expq.pop_front();
                        last_exp = e;
                    end else begin
                        check(1'b0, "R10", "new frame with nothing queued", 64'(underrun), 64'd1);
                        e = last_exp;
                    end
                    check(rxd == exp_frame(fmt, wl_of(wlen_sel), e[47:24], e[23:0]),
                          {req_of(fmt), "/R1/R7/R9"}, "frame data", rxd, exp_frame(fmt, wl_of(wlen_sel), e[47:24], e[23:0]));
                    check(rxf == exp_fclk(fmt), {req_of(fmt), "/R8"}, "frame clock pattern", rxf, exp_fclk(fmt));
                    check(r6_bad == 0, "R6", "sdo moved while bit clock high", 64'(r6_bad), 64'd0);
                    r6_bad = 0;
                end
            end
        end
    end

    // Data must be unchanged at the falling bit clock (R6).
    initial begin
        forever begin
            @(negedge bclk_mon);
            if (mon_en && rx_on && (sdo !== rise_sdo)) r6_bad++;
        end
    end

    // Slave clock source: bench-generated bit and frame clocks.
    initial begin
        int sdiv, sslot;
        sdiv = 0;
        sslot = FB - 1;
        forever begin
            @(negedge clk);
            if (!sgen_en) begin
                bclk_in = 1'b0;
                fclk_in = 1'b0;
                sdiv = 0;
                sslot = FB - 1;
            end else begin
                sdiv++;
                if (sdiv == HALF) begin
                    sdiv = 0;
                    if (bclk_in) begin
                        sslot = (sslot + 1) % FB;
                        fclk_in = fc_rule(fmt, sslot);
                        bclk_in = 1'b0;
                    end else begin
                        bclk_in = 1'b1;
                    end
                end
            end
        end
    end

    // Driver: offer one pair and queue it once it is taken (R9).
    task automatic send_pair(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        expq.push_back({l, r});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_phase(input int ph, input logic [1:0] f, input logic [1:0] w,
                             input logic m, input int npairs);
        int guard;
        mon_en  = 1'b0;
        sgen_en = 1'b0;
        in_valid = 1'b0;
        rst_n   = 1'b0;
        fmt = f;
        wlen_sel = w;
        master_en = m;
        repeat (4) @(negedge clk);
        check(sdo == 1'b0, "R11", "sdo in reset", 64'(sdo), 64'd0);
        check(in_ready == 1'b1, "R11", "in_ready in reset", 64'(in_ready), 64'd1);
        check(underrun == 1'b0, "R11", "underrun in reset", 64'(underrun), 64'd0);
        check(bclk_out == 1'b0 && fclk_out == 1'b0, "R11", "clocks in reset",
              64'({bclk_out, fclk_out}), 64'd0);
        check(bus_drive == m, "R8", "bus_drive follows mode", 64'(bus_drive), 64'(m));
        expq.delete();
        last_exp = '0;
        rx_on = 1'b0;
        rx_idx = 0;
        prev_fc = 1'b0;
        r6_bad = 0;
        under_frames = 0;
        mon_en = 1'b1;
        rst_n = 1'b1;
        sgen_en = !m;
        for (int i = 0; i < npairs; i++) begin
            logic [31:0] a, b;
            a = (32'h9E37_79B9 * (i + 1)) ^ (32'h0013_5791 * (ph + 1));
            b = ~(a * 32'h0001_0DCD) ^ 32'h00A5_5A3C;
            send_pair(a[23:0], b[23:0]);
        end
        guard = 0;
        while ((expq.size() != 0 || under_frames < 2) && guard < 12 * FB * 2 * HALF) begin
            @(negedge clk);
            guard++;
        end
        check(expq.size() == 0, "R9", "all taken pairs sent in order", 64'(expq.size()), 64'd0);
        check(under_frames >= 2, "R10", "underrun frames repeat last pair", 64'(under_frames), 64'd2);
        check(in_ready == 1'b1, "R9", "ready while nothing waits", 64'(in_ready), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        run_phase(0, 2'd1, 2'd3, 1'b1, 4);   // R2 left-aligned, 24 bits, master
        run_phase(1, 2'd2, 2'd0, 1'b1, 4);   // R3 inter-IC sound, 16 bits, master
        run_phase(2, 2'd0, 2'd1, 1'b1, 4);   // R4 right-aligned, 18 bits, master
        run_phase(3, 2'd3, 2'd2, 1'b1, 4);   // R5 DSP, 20 bits, master
        run_phase(4, 2'd3, 2'd3, 1'b1, 3);   // R5 DSP, 24 bits, master
        run_phase(5, 2'd2, 2'd3, 1'b0, 3);   // R3 inter-IC sound, slave
        run_phase(6, 2'd1, 2'd2, 1'b0, 3);   // R2 left-aligned, slave
        run_phase(7, 2'd0, 2'd0, 1'b0, 3);   // R4 right-aligned, 16 bits, slave
        mon_en = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule